// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, A and B. Each bus has its own storage register. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. Each register loads when its own capture strobe falls. An active-low output enable and a direction input decide which bus this block drives, if it drives one at all. For each direction, a select input decides whether the driven bus carries live data taken from the other bus or the stored register value. Data is never inverted.

The pads are not modelled as tristates. Each bus has a separate input vector, output vector and enable bit, so the pad ring does the final tristate merge. All state runs in a single system clock domain. Capture strobes are sampled levels, and a falling strobe is detected against the value sampled one clock earlier. A register samples the value actually present on its bus: the value this block drives when that bus is enabled, and the external input otherwise. As a result, a value the block is driving can be stored in one register or in both.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are both 0. A rising clock edge with `rst` high clears both stored values to zero.
- R2: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R3: While `oe_n` is 0 and `rst` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. The two enables are never 1 together.
- R4: `b_out` equals `a_in` in the same cycle when `sel_ab`=0, and equals the stored A-to-B value when `sel_ab`=1. No bit is inverted.
- R5: `a_out` equals `b_in` in the same cycle when `sel_ba`=0, and equals the stored B-to-A value when `sel_ba`=1.
- R6: The A-to-B register loads the value on the A bus at the first rising clock edge where `cap_ab` is sampled 0 after having been sampled 1 at the previous edge.
- R7: The B-to-A register loads the value on the B bus at the first rising clock edge where `cap_ba` is sampled 0 after having been sampled 1 at the previous edge.
- R8: Captures take place whatever the values of `oe_n`, `dir` and the select inputs. With `oe_n`=1, the two registers can load their own buses at the same edge.
- R9: When a bus is enabled, its register samples the value this block drives onto it rather than the external input. Two captures at the same edge each use the values held before that edge.
- R10: A stored value does not change at any edge that is not a capture edge. This covers a strobe held high, a strobe held low and a rising strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A-to-B value |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B-to-A value |
| cap_ab | input | 1 | Capture strobe for the A-to-B register (falling edge) |
| cap_ba | input | 1 | Capture strobe for the B-to-A register (falling edge) |
| a_in | input | WIDTH | Value seen at the A pads |
| a_out | output | WIDTH | Value offered to the A pads |
| a_oe | output | 1 | Drive enable for the A pads |
| b_in | input | WIDTH | Value seen at the B pads |
| b_out | output | WIDTH | Value offered to the B pads |
| b_oe | output | 1 | Drive enable for the B pads |

## Verification
The enables and the live data paths are combinational, so they respond in the same cycle as a stimulus. A stored value, or a reset clear, appears one rising edge after the strobe or reset level is applied, and only if the strobe was sampled high at the edge before. The bench changes inputs just after a falling clock edge. For each vector it queues the expected post-edge outputs, computed from its own model of the two registers and their strobe history. The monitor takes each expectation 4 ns after the next rising edge, when both the register updates and the combinational paths have settled. The vector set covers all sixteen combinations of enable, direction and the two selects, simultaneous captures, captures of driven data, and strobes held flat or rising.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int BUS_W   = 8;
    localparam int N_DIR   = 2;
    localparam int IDX_AB  = 0;
    localparam int IDX_BA  = 1;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } ctl_t;

    function automatic drive_e decode_drive(input logic rst, input ctl_t c);
        if (rst || c.oe_n) return DRV_NONE;
        return c.dir ? DRV_B : DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_fall_detect.sv
module xcvr_fall_detect #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lvl,
    output logic [LANES-1:0] fall
);

    logic [LANES-1:0] lvl_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl[i];
        end
        assign fall[i] = lvl_q[i] & ~lvl[i];
    end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R6 / R7: the value on the bus at a capture edge is what is held afterwards
    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    always_comb begin
        y = sel ? stored : live;
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int WIDTH = xcvr_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    import xcvr_pkg::*;

    localparam int ND = N_DIR;

    ctl_t   ctl;
    drive_e drv;
    logic [ND-1:0]            strobe;
    logic [ND-1:0]            fall;
    logic [ND-1:0]            sel_v;
    logic [WIDTH-1:0]         a_seen;
    logic [WIDTH-1:0]         b_seen;
    logic [ND-1:0][WIDTH-1:0] held;
    logic [ND-1:0][WIDTH-1:0] routed;

    assign ctl = '{oe_n: oe_n, dir: dir, sel_ab: sel_ab, sel_ba: sel_ba};
    assign drv = decode_drive(rst, ctl);

    assign a_oe = (drv == DRV_A);
    assign b_oe = (drv == DRV_B);

    // value actually present on each bus
    assign a_seen = a_oe ? a_out : a_in;
    assign b_seen = b_oe ? b_out : b_in;

    assign strobe[IDX_AB] = cap_ab;
    assign strobe[IDX_BA] = cap_ba;
    assign sel_v[IDX_AB]  = ctl.sel_ab;
    assign sel_v[IDX_BA]  = ctl.sel_ba;

    xcvr_fall_detect #(.LANES(ND)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (strobe),
        .fall (fall)
    );

    for (genvar i = 0; i < ND; i++) begin : g_dir
        xcvr_store #(.W(WIDTH)) u_store (
            .clk  (clk),
            .rst  (rst),
            .load (fall[i]),
            .d    ((i == IDX_AB) ? a_seen : b_seen),
            .q    (held[i])
        );
        xcvr_route #(.W(WIDTH)) u_route (
            .sel    (sel_v[i]),
            .live   ((i == IDX_AB) ? a_in : b_in),
            .stored (held[i]),
            .y      (routed[i])
        );
    end

    assign b_out = routed[IDX_AB];
    assign a_out = routed[IDX_BA];

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (held == '0));

    assert_quiet_R2: assert property (@(posedge clk)
        oe_n |-> (!a_oe && !b_oe));

    assert_one_driver_R3: assert property (@(posedge clk)
        !(a_oe && b_oe));

    assert_b_live_R4: assert property (@(posedge clk) disable iff (rst)
        (b_oe && !sel_ab) |-> (b_out == a_in));

    assert_a_stored_R5: assert property (@(posedge clk) disable iff (rst)
        (a_oe && sel_ba) |-> (a_out == held[IDX_BA]));

endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;

    localparam int W = 8;

    typedef struct {
        string      tag;
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic       a_oe;
        logic       b_oe;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic cap_ab = 1'b0, cap_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    exp_t q[$];

    // reference state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic p_ab = 1'b0, p_ba = 1'b0;

    always #5 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic step(input logic r, input logic oen, input logic d,
                        input logic sab, input logic sba,
                        input logic cab, input logic cba,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
        exp_t e;
        logic ea, eb;
        logic [W-1:0] ra, rb;
        @(negedge clk);
        rst = r; oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
        cap_ab = cab; cap_ba = cba; a_in = a; b_in = b;
        ea = !r && !oen && !d;
        eb = !r && !oen && d;
        ra = ea ? (sba ? m_ba : b) : a;
        rb = eb ? (sab ? m_ab : a) : b;
        if (r) begin
            m_ab = '0; m_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
        end else begin
            if (p_ab && !cab) m_ab = ra;
            if (p_ba && !cba) m_ba = rb;
            p_ab = cab; p_ba = cba;
        end
        e.tag   = tag;
        e.a_out = sba ? m_ba : b;
        e.b_out = sab ? m_ab : a;
        e.a_oe  = ea;
        e.b_oe  = eb;
        q.push_back(e);
    endtask

    // monitor: compare 4 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #4;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if (a_oe !== e.a_oe) begin
                    miscompares++;
                    $display("FAIL %s a_oe got %b exp %b", e.tag, a_oe, e.a_oe);
                end
                if (b_oe !== e.b_oe) begin
                    miscompares++;
                    $display("FAIL %s b_oe got %b exp %b", e.tag, b_oe, e.b_oe);
                end
                if (a_out !== e.a_out) begin
                    miscompares++;
                    $display("FAIL %s a_out got %h exp %h", e.tag, a_out, e.a_out);
                end
                if (b_out !== e.b_out) begin
                    miscompares++;
                    $display("FAIL %s b_out got %h exp %h", e.tag, b_out, e.b_out);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then load data, then reset again and read back zeros
        step(1, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R1");
        step(1, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R1");
        step(0, 1, 0, 1, 1, 1, 1, 8'h5A, 8'hA5, "R6");
        step(0, 1, 0, 1, 1, 0, 0, 8'h5A, 8'hA5, "R8");
        step(1, 0, 1, 1, 1, 0, 0, 8'h11, 8'h22, "R1");
        step(0, 1, 0, 1, 1, 0, 0, 8'h11, 8'h22, "R1");

        // preload known values: AB <= 0x96, BA <= 0x69 (outputs off)
        step(0, 1, 0, 1, 1, 1, 1, 8'h96, 8'h69, "R8");
        step(0, 1, 0, 1, 1, 0, 0, 8'h96, 8'h69, "R8");

        // R2 R3 R4 R5: every combination of oe_n, dir, sel_ab, sel_ba
        for (int k = 0; k < 16; k++) begin
            step(0, k[3], k[2], k[1], k[0], 0, 0, 8'h3C, 8'hC3,
                 k[3] ? "R2" : (k[1] ? "R4" : "R5"));
            step(0, k[3], k[2], k[1], k[0], 0, 0, 8'hF0, 8'h0F, "R3");
        end

        // R10: strobe held low, rising, held high: no load
        step(0, 1, 0, 1, 1, 0, 0, 8'h01, 8'h02, "R10");
        step(0, 1, 0, 1, 1, 1, 1, 8'h03, 8'h04, "R10");
        step(0, 1, 0, 1, 1, 1, 1, 8'h05, 8'h06, "R10");

        // R6: A-to-B load of live A with B driven
        step(0, 0, 1, 0, 1, 0, 1, 8'h7E, 8'h81, "R6");
        step(0, 0, 1, 1, 1, 0, 1, 8'h7E, 8'h81, "R6");
        // R7: B-to-A load of external B while A driven from store
        step(0, 0, 0, 1, 1, 0, 0, 8'h44, 8'hBD, "R7");
        step(0, 0, 0, 1, 1, 0, 0, 8'h44, 8'hBD, "R7");
        step(0, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R10");

        // R9: A driven from store; A-to-B captures the driven value
        step(0, 0, 0, 1, 1, 1, 0, 8'hEE, 8'h12, "R9");
        step(0, 0, 0, 1, 1, 0, 0, 8'hEE, 8'h12, "R9");
        // R9: B driven with live A, both registers capture same edge
        step(0, 0, 1, 0, 1, 1, 1, 8'h37, 8'hC8, "R9");
        step(0, 0, 1, 0, 1, 0, 0, 8'h37, 8'hC8, "R9");
        step(0, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R9");
        // R9: A driven from store while both capture: AB takes old BA
        step(0, 0, 0, 1, 1, 1, 1, 8'h55, 8'hAA, "R9");
        step(0, 0, 0, 1, 1, 0, 0, 8'h55, 8'hAA, "R9");
        step(0, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R9");

        // R8: outputs off, independent captures of each bus
        step(0, 1, 1, 1, 1, 1, 1, 8'hC0, 8'h0C, "R8");
        step(0, 1, 1, 1, 1, 0, 0, 8'hC0, 8'h0C, "R8");
        step(0, 1, 1, 1, 1, 0, 0, 8'hFF, 8'hFF, "R10");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule